// File: doc/BRIEF.md
# Paired Halfword Unsigned Adder Unit

This execution unit takes one 32-bit instruction word and checks it against a paired-halfword unsigned add, in a wrapping form and a saturating form. A mode input picks which of two instruction layouts is decoded. The two layouts place the register fields in different bit positions. The caller supplies the two 32-bit source operands. The unit adds the upper 16-bit lanes together and the lower 16-bit lanes together, with no carry between the lanes. It then returns a 64-bit destination value, sign-extended from result bit 31, together with the destination register index.

A 32-bit control register holds a sticky overflow flag at bit 20. Only this unit sets that flag. Reset clears it, and so does a separate full-word write port. That write port is also the only way the other 31 bits change.

A word that matches neither form raises a reserved-instruction indication. A recognised word issued while the DSP enable input is low raises a DSP-disabled indication. In both of these cases no result is produced and the control register is not touched. All outputs are registered and appear one clock after the input strobe.

Top module: `phadd_unit`

## Requirements
- R1: Each 16-bit lane is added on its own. A carry out of the lower lane (bits 15..0) never reaches the upper lane (bits 31..16).
- R2: In the wrapping form, each lane result is the lane sum modulo 65,536.
- R3: In the saturating form, a lane sum above 0xFFFF becomes 0xFFFF. A lane that does not overflow gives the plain sum.
- R4: out_result[31:0] holds the upper lane in bits 31..16 and the lower lane in bits 15..0. Bits 63..32 are copies of bit 31.
- R5: If either lane sum exceeds 0xFFFF, in either form, ctl_reg bit 20 is 1 after the result cycle.
- R6: ctl_reg bit 20 is sticky. It is cleared only by reset or by the write port. No bit changes except through ctl_wr_en, which loads ctl_wr_data. An overflow in the same cycle as a write still leaves bit 20 set.
- R7: With enc_mode = 0, the layout is: bits 31..26 = 011111, first source index in 25..21, second source index in 20..16, destination in 15..11, selector in 10..6, bits 5..0 = 010000. Selector 01000 chooses wrapping and 01100 chooses saturating. src_s holds the first source operand and src_t the second.
- R8: With enc_mode = 1, the layout is: bits 31..26 = 000000, second source index in 25..21, first source index in 20..16, destination in 15..11, bits 10..0 = 00100001101 for wrapping or 10100001101 for saturating.
- R9: A strobed word that matches neither form under the selected mode sets out_resv_exc for one cycle. out_valid stays 0 and ctl_reg is unchanged.
- R10: A recognised word strobed while dsp_enable is 0 sets out_dsp_exc for one cycle. out_valid stays 0 and ctl_reg is unchanged.
- R11: out_valid, out_rd and out_result update on the clock edge that samples in_valid. out_valid is 0 in any cycle that follows a cycle with no strobe.
- R12: After reset, every output and ctl_reg is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| enc_mode | input | 1 | 0 selects the standard layout, 1 selects the compact layout |
| dsp_enable | input | 1 | DSP unit enabled |
| src_s | input | 32 | First source operand |
| src_t | input | 32 | Second source operand |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control register write value |
| out_valid | output | 1 | Result valid |
| out_rd | output | 5 | Destination register index |
| out_result | output | 64 | Sign-extended destination value |
| out_resv_exc | output | 1 | Reserved-instruction indication |
| out_dsp_exc | output | 1 | DSP-disabled indication |
| ctl_reg | output | 32 | Control register contents |

## Verification
The bench builds the unit with its default parameters: two lanes of 16 bits and the flag at bit 20. With 16-bit lanes, the 0xFFFF boundary can be reached directly, so directed operands land exactly on the wrap point and the clamp point in each lane. Random operands drawn from a mix of full-range values and values near the boundary make overflow in one lane only, and in both lanes, a common event. Random mixes of layout mode, enable and corrupted words also exercise every exception path against the sticky flag.

// File: rtl/phadd_pkg.sv
package phadd_pkg;
  localparam int INSN_W = 32;
  localparam int REG_IDX_W = 5;

  typedef enum logic {ENC_STD = 1'b0, ENC_CMP = 1'b1} enc_fmt_e;

  typedef struct packed {
    logic                 hit;
    logic                 sat;
    logic [REG_IDX_W-1:0] rd;
  } dec_t;

  localparam logic [5:0]  STD_MAJOR    = 6'b011111;
  localparam logic [5:0]  STD_FUNC     = 6'b010000;
  localparam logic [4:0]  STD_SEL_WRAP = 5'b01000;
  localparam logic [4:0]  STD_SEL_SAT  = 5'b01100;
  localparam logic [5:0]  CMP_MAJOR    = 6'b000000;
  localparam logic [10:0] CMP_MIN_WRAP = 11'b00100001101;
  localparam logic [10:0] CMP_MIN_SAT  = 11'b10100001101;
endpackage

// File: rtl/phadd_decode.sv
module phadd_decode
  import phadd_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  enc_fmt_e          fmt,
  output dec_t              dec
);
  always_comb begin
    dec     = '0;
    dec.rd  = insn[15:11];
    unique case (fmt)
      ENC_STD: begin
        if (insn[31:26] == STD_MAJOR && insn[5:0] == STD_FUNC) begin
          if (insn[10:6] == STD_SEL_WRAP) begin
            dec.hit = 1'b1;
            dec.sat = 1'b0;
          end else if (insn[10:6] == STD_SEL_SAT) begin
            dec.hit = 1'b1;
            dec.sat = 1'b1;
          end
        end
      end
      ENC_CMP: begin
        if (insn[31:26] == CMP_MAJOR) begin
          if (insn[10:0] == CMP_MIN_WRAP) begin
            dec.hit = 1'b1;
            dec.sat = 1'b0;
          end else if (insn[10:0] == CMP_MIN_SAT) begin
            dec.hit = 1'b1;
            dec.sat = 1'b1;
          end
        end
      end
      default: dec = '0;
    endcase
  end
endmodule

// File: rtl/phadd_lanes.sv
module phadd_lanes #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  localparam int VEC_W = LANE_W * LANES
) (
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  input  logic             sat,
  output logic [VEC_W-1:0] sum,
  output logic [LANES-1:0] lane_ovf
);
  // Returns {overflow, lane value}; clamps to all-ones when requested.
  function automatic logic [LANE_W:0] lane_add(
    input logic [LANE_W-1:0] a,
    input logic [LANE_W-1:0] b,
    input logic              clamp
  );
    logic [LANE_W:0] raw;
    raw = {1'b0, a} + {1'b0, b};
    if (clamp && raw[LANE_W]) return {1'b1, {LANE_W{1'b1}}};
    return raw;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign {lane_ovf[g], sum[g*LANE_W +: LANE_W]} =
      lane_add(opa[g*LANE_W +: LANE_W], opb[g*LANE_W +: LANE_W], sat);
  end
endmodule

// File: rtl/phadd_unit.sv
module phadd_unit
  import phadd_pkg::*;
#(
  parameter int LANE_W   = 16,
  parameter int LANES    = 2,
  parameter int CTL_W    = 32,
  parameter int FLAG_BIT = 20,
  localparam int DATA_W  = LANE_W * LANES,
  localparam int RES_W   = 2 * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [INSN_W-1:0]    insn,
  input  logic                 enc_mode,
  input  logic                 dsp_enable,
  input  logic [DATA_W-1:0]    src_s,
  input  logic [DATA_W-1:0]    src_t,
  input  logic                 ctl_wr_en,
  input  logic [CTL_W-1:0]     ctl_wr_data,
  output logic                 out_valid,
  output logic [REG_IDX_W-1:0] out_rd,
  output logic [RES_W-1:0]     out_result,
  output logic                 out_resv_exc,
  output logic                 out_dsp_exc,
  output logic [CTL_W-1:0]     ctl_reg
);
  enc_fmt_e          fmt_w;
  dec_t              dec_w;
  logic [DATA_W-1:0] sum_w;
  logic [LANES-1:0]  lane_ovf_w;

  // Named internal events, observed by the checker.
  logic fire_ok_w, resv_w, dspoff_w, flag_set_w;

  assign fmt_w = enc_fmt_e'(enc_mode);

  phadd_decode u_dec (
    .insn (insn),
    .fmt  (fmt_w),
    .dec  (dec_w)
  );

  phadd_lanes #(.LANE_W(LANE_W), .LANES(LANES)) u_lanes (
    .opa      (src_s),
    .opb      (src_t),
    .sat      (dec_w.sat),
    .sum      (sum_w),
    .lane_ovf (lane_ovf_w)
  );

  assign fire_ok_w  = in_valid & dec_w.hit & dsp_enable;
  assign resv_w     = in_valid & ~dec_w.hit;
  assign dspoff_w   = in_valid & dec_w.hit & ~dsp_enable;
  assign flag_set_w = fire_ok_w & (|lane_ovf_w);

  logic [CTL_W-1:0] ctl_base_w, flag_mask_w;
  assign ctl_base_w  = ctl_wr_en ? ctl_wr_data : ctl_reg;
  assign flag_mask_w = CTL_W'(flag_set_w) << FLAG_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_rd       <= '0;
      out_result   <= '0;
      out_resv_exc <= 1'b0;
      out_dsp_exc  <= 1'b0;
      ctl_reg      <= '0;
    end else begin
      out_valid    <= fire_ok_w;
      out_resv_exc <= resv_w;
      out_dsp_exc  <= dspoff_w;
      ctl_reg      <= ctl_base_w | flag_mask_w;
      if (fire_ok_w) begin
        out_rd     <= dec_w.rd;
        out_result <= {{(RES_W-DATA_W){sum_w[DATA_W-1]}}, sum_w};
      end
    end
  end
endmodule

// File: rtl/phadd_chk.sv
module phadd_chk #(
  parameter int DATA_W   = 32,
  parameter int CTL_W    = 32,
  parameter int FLAG_BIT = 20,
  localparam int RES_W   = 2 * DATA_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr_en,
  input logic             fire_ok_w,
  input logic             resv_w,
  input logic             dspoff_w,
  input logic             flag_set_w,
  input logic             out_valid,
  input logic [RES_W-1:0] out_result,
  input logic             out_resv_exc,
  input logic             out_dsp_exc,
  input logic [CTL_W-1:0] ctl_reg
);
  localparam logic [CTL_W-1:0] KEEP_MASK = ~(CTL_W'(1) << FLAG_BIT);

  AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[RES_W-1:DATA_W] == {DATA_W{out_result[DATA_W-1]}})); // R4
  AST_FLAG_ON_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_w |=> ctl_reg[FLAG_BIT]); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_reg[FLAG_BIT] && !ctl_wr_en) |=> ctl_reg[FLAG_BIT]); // R6
  AST_OTHER_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> $stable(ctl_reg & KEEP_MASK)); // R6
  AST_RESV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    resv_w |=> (out_resv_exc && !out_valid && !out_dsp_exc)); // R9
  AST_DSPOFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dspoff_w |=> (out_dsp_exc && !out_valid && !out_resv_exc)); // R10
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ok_w |=> out_valid); // R11
  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_resv_exc, out_dsp_exc})); // R11
endmodule

bind phadd_unit phadd_chk #(.DATA_W(DATA_W), .CTL_W(CTL_W), .FLAG_BIT(FLAG_BIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_wr_en    (ctl_wr_en),
  .fire_ok_w    (fire_ok_w),
  .resv_w       (resv_w),
  .dspoff_w     (dspoff_w),
  .flag_set_w   (flag_set_w),
  .out_valid    (out_valid),
  .out_result   (out_result),
  .out_resv_exc (out_resv_exc),
  .out_dsp_exc  (out_dsp_exc),
  .ctl_reg      (ctl_reg)
);

// File: tb/tb_phadd_unit.sv
module tb_phadd_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic        enc_mode = 1'b0;
  logic        dsp_enable = 1'b1;
  logic [31:0] src_s = '0;
  logic [31:0] src_t = '0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic        out_valid;
  logic [4:0]  out_rd;
  logic [63:0] out_result;
  logic        out_resv_exc;
  logic        out_dsp_exc;
  logic [31:0] ctl_reg;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_ctl = '0;

  always #(CLK_P/2) clk = ~clk;

  phadd_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .enc_mode(enc_mode), .dsp_enable(dsp_enable), .src_s(src_s), .src_t(src_t),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .out_valid(out_valid), .out_rd(out_rd), .out_result(out_result),
    .out_resv_exc(out_resv_exc), .out_dsp_exc(out_dsp_exc), .ctl_reg(ctl_reg)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference lane arithmetic, done with 32-bit integers.
  function automatic logic [15:0] ref_lane(input int unsigned a, input int unsigned b,
                                           input logic sat);
    int unsigned s = a + b;
    if (s > 65535) return sat ? 16'hFFFF : 16'(s - 65536);
    return 16'(s);
  endfunction

  function automatic logic [31:0] w_std(input logic [4:0] s, input logic [4:0] t,
                                        input logic [4:0] d, input logic sat);
    return {6'b011111, s, t, d, (sat ? 5'b01100 : 5'b01000), 6'b010000};
  endfunction

  function automatic logic [31:0] w_cmp(input logic [4:0] s, input logic [4:0] t,
                                        input logic [4:0] d, input logic sat);
    return {6'b000000, t, s, d, (sat ? 11'b10100001101 : 11'b00100001101)};
  endfunction

  // kind: 0 = good result expected, 1 = reserved, 2 = DSP disabled, 3 = idle
  task automatic run(input string req, input int kind, input logic mode,
                     input logic [31:0] word, input logic en, input logic sat,
                     input logic [4:0] rd, input logic [31:0] a, input logic [31:0] b,
                     input logic wr, input logic [31:0] wdata);
    logic [15:0] hi, lo;
    logic ovf;
    hi  = ref_lane(a[31:16], b[31:16], sat);
    lo  = ref_lane(a[15:0],  b[15:0],  sat);
    ovf = ({16'h0, a[31:16]} + {16'h0, b[31:16]} > 32'hFFFF) ||
          ({16'h0, a[15:0]}  + {16'h0, b[15:0]}  > 32'hFFFF);
    in_valid = (kind != 3); insn = word; enc_mode = mode; dsp_enable = en;
    src_s = a; src_t = b; ctl_wr_en = wr; ctl_wr_data = wdata;
    if (wr) exp_ctl = wdata;
    if (kind == 0 && ovf) exp_ctl[20] = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; ctl_wr_en = 1'b0;
    check(req, "out_valid", 64'(out_valid), 64'(kind == 0));
    check(req, "out_resv_exc", 64'(out_resv_exc), 64'(kind == 1));
    check(req, "out_dsp_exc", 64'(out_dsp_exc), 64'(kind == 2));
    check(req, "ctl_reg", 64'(ctl_reg), 64'(exp_ctl));
    if (kind == 0) begin
      check(req, "out_rd", 64'(out_rd), 64'(rd));
      check(req, "out_result", out_result, {{32{hi[15]}}, hi, lo});
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12", "out_valid", 64'(out_valid), 64'd0);
    check("R12", "out_result", out_result, 64'd0);
    check("R12", "out_rd", 64'(out_rd), 64'd0);
    check("R12", "exc", 64'({out_resv_exc, out_dsp_exc}), 64'd0);
    check("R12", "ctl_reg", 64'(ctl_reg), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R11 idle cycle leaves out_valid low
    run("R11", 3, 0, '0, 1, 0, 0, 32'h1, 32'h1, 0, '0);
    // R1 R2 lower lane wraps, no carry into the upper lane
    run("R1", 0, 0, w_std(5'd1, 5'd2, 5'd3, 0), 1, 0, 5'd3, 32'h0000FFFF, 32'h00000001, 0, '0);
    // R2 R5 upper lane wraps, flag set
    run("R2", 0, 0, w_std(5'd4, 5'd5, 5'd6, 0), 1, 0, 5'd6, 32'hFFFF0001, 32'h00010002, 0, '0);
    // R6 clear through write port, other bits loaded
    run("R6", 3, 0, '0, 1, 0, 0, '0, '0, 1, 32'hA5A5A5A5);
    // R3 R4 saturate both lanes, all-ones extension
    run("R3", 0, 0, w_std(5'd7, 5'd8, 5'd9, 1), 1, 1, 5'd9, 32'h8000FFFF, 32'h80000001, 0, '0);
    // R6 flag stays set on a following non-overflowing op
    run("R6", 0, 0, w_std(5'd1, 5'd1, 5'd2, 1), 1, 1, 5'd2, 32'h7FFF0000, 32'h00010000, 0, '0);
    // R6 write of zero in the same cycle as an overflow keeps bit 20
    run("R6", 0, 0, w_std(5'd1, 5'd1, 5'd10, 0), 1, 0, 5'd10, 32'h0000FFFF, 32'h0000FFFF, 1, 32'h0);
    run("R6", 3, 0, '0, 1, 0, 0, '0, '0, 1, 32'h0);
    // R3 saturating form without overflow gives plain sums
    run("R3", 0, 0, w_std(5'd2, 5'd3, 5'd11, 1), 1, 1, 5'd11, 32'h12340FFF, 32'h00011000, 0, '0);
    // R8 compact layout, sign extension from bit 31
    run("R8", 0, 1, w_cmp(5'd9, 5'd17, 5'd31, 0), 1, 0, 5'd31, 32'h7FFF1111, 32'h00012222, 0, '0);
    run("R8", 0, 1, w_cmp(5'd3, 5'd4, 5'd5, 1), 1, 1, 5'd5, 32'hFFF00005, 32'h00200003, 0, '0);
    // R9 standard word in compact mode, compact word in standard mode, bad selector
    run("R9", 1, 1, w_std(5'd1, 5'd2, 5'd3, 0), 1, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, '0);
    run("R9", 1, 0, w_cmp(5'd1, 5'd2, 5'd3, 1), 1, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, '0);
    run("R9", 1, 0, w_std(5'd1, 5'd2, 5'd3, 0) ^ 32'h0000_0040, 1, 0, 0, 32'hFFFFFFFF, 32'h1, 0, '0);
    // R10 disabled unit: no write, no flag update
    run("R10", 2, 0, w_std(5'd1, 5'd2, 5'd3, 1), 0, 1, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, '0);
    run("R10", 2, 1, w_cmp(5'd1, 5'd2, 5'd3, 0), 0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, '0);
    // R7 standard layout with varied fields
    run("R7", 0, 0, w_std(5'd31, 5'd0, 5'd17, 0), 1, 0, 5'd17, 32'h00010002, 32'h00030004, 0, '0);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic mode, sat, en, wr, bad;
      logic [4:0] rs, rt, rd;
      logic [31:0] a, b, w, wd;
      int kind;
      mode = 1'($urandom); sat = 1'($urandom);
      en = ($urandom % 8) != 0; bad = ($urandom % 8) == 0; wr = ($urandom % 16) == 0;
      rs = 5'($urandom); rt = 5'($urandom); rd = 5'($urandom); wd = $urandom;
      a = ($urandom % 2) ? $urandom : {16'hFFF0 | 16'($urandom % 16), 16'hFFF0 | 16'($urandom % 16)};
      b = ($urandom % 2) ? $urandom : {16'($urandom % 32), 16'($urandom % 32)};
      w = mode ? w_cmp(rs, rt, rd, sat) : w_std(rs, rt, rd, sat);
      if (bad) w = w ^ 32'h0000_0001;
      kind = bad ? 1 : (en ? 0 : 2);
      run(mode ? "R8" : "R7", kind, mode, w, en, sat, rd, a, b, wr, wd);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule